// File: doc/BRIEF.md
# Ordered Store Drain Buffer

This block sits between the store side of a processor and a memory write port. It takes stores and fence tokens, holds up to `DEPTH` of them, and hands stores to memory one at a time over a valid/ready handshake. A mode input chooses how the entries leave the buffer. In strict mode each store leaves in issue order. In relaxed mode a store may pass older ones. It does so when the memory bank it targets is idle while an older store waits on a busy bank.

The ordering rules in relaxed mode are as follows. A store never passes a fence that is still in the buffer. A store never passes an older store to the same address. Among the stores that may leave, the oldest one goes first. A fence never produces a memory write. It leaves the buffer by itself once it is the oldest entry.

Software cannot assume that a device write has landed just because some other event took place. To know that, it raises a flush request. The buffer then refuses new work until every held entry has drained, and it answers with a one-cycle done pulse.

Top module: `store_drain_buf`

## Requirements
- R1: While reset is held and after it is released, `s_ready` is 1, `m_valid` is 0 and `flush_done` is 0.
- R2: The buffer holds `DEPTH` entries, counting stores and fences alike. When all `DEPTH` entries are occupied, `s_ready` is 0. A store offered while the buffer is full is not taken and never appears on the memory port.
- R3: With `relax_mode`=0, stores reach the memory port in exactly their issue order. Only the oldest entry may be offered. While the bank of the oldest entry is busy, nothing is offered.
- R4: With `relax_mode`=1, the store offered is the oldest store that meets all three conditions: its bank is idle, no fence is older than it in the buffer, and no older store has the same address. A younger store to an idle bank therefore passes an older store stuck on a busy bank.
- R5: Two stores to the same address reach memory in issue order in both modes.
- R6: A fence is an entry with `s_fence`=1. It takes a slot and is never shown on the memory port. It blocks every younger store until all older entries are gone. When it becomes the oldest entry, it leaves within one cycle.
- R7: The bank of an address is its low `log2(NBANK)` bits. `m_valid` is never 1 for an address whose bit in `m_bank_busy` is 1.
- R8: An entry leaves only on a cycle where `m_valid` and `m_ready` are both 1. In strict mode, while the port is stalled and the bank flags do not change, the offered address and data hold steady.
- R9: A one-cycle `flush_req` drops `s_ready` from the next cycle until the done pulse. The flush covers every entry accepted up to and including the request cycle.
- R10: `flush_done` is a single-cycle pulse on the cycle after the buffer is seen empty with a flush pending. A flush of an empty buffer pulses two clock edges after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| relax_mode | input | 1 | 0 = strict issue order, 1 = relaxed draining |
| s_valid | input | 1 | Store-side request valid |
| s_ready | output | 1 | Buffer can take a request |
| s_fence | input | 1 | 1 = fence token, 0 = store |
| s_addr | input | ADDR_W | Store word address |
| s_data | input | DATA_W | Store data |
| s_be | input | DATA_W/8 | Store byte enables |
| m_valid | output | 1 | Memory write offered |
| m_ready | input | 1 | Memory accepts the offered write |
| m_addr | output | ADDR_W | Offered write address |
| m_data | output | DATA_W | Offered write data |
| m_be | output | DATA_W/8 | Offered byte enables |
| m_bank_busy | input | NBANK | One flag per memory bank, 1 = bank cannot take a write |
| flush_req | input | 1 | Request to drain everything held |
| flush_done | output | 1 | One-cycle pulse: the flush has completed |

## Verification
The bench builds the block with its defaults: `DEPTH`=8, `NBANK`=4, 16-bit addresses, 32-bit data, and relaxed logic present. With four banks, each test store can be placed in a bank of its own. Holding one bank busy then forces the strict head to stall and lets relaxed mode reorder in a predictable way. Eight slots are few enough that the full condition and a refused ninth store are reached directly. The fence case places a store on a busy bank ahead of the fence. This shows that a younger store on an idle bank still waits behind the fence.

// File: rtl/sb_pkg.sv
package sb_pkg;
   typedef enum logic {
      SB_STORE = 1'b0,
      SB_FENCE = 1'b1
   } sb_kind_e;
endpackage

// File: rtl/sb_slots.sv
module sb_slots
   import sb_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int BE_W   = DATA_W / 8,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  sb_kind_e          push_kind,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic [DATA_W-1:0] push_data,
   input  logic [BE_W-1:0]   push_be,
   input  logic              pop,
   input  logic [IDX_W-1:0]  pop_idx,
   output logic [DEPTH-1:0]  slot_vld,
   output logic [DEPTH-1:0]  slot_fence,
   output logic [ADDR_W-1:0] slot_addr [DEPTH],
   output logic [DATA_W-1:0] slot_data [DEPTH],
   output logic [BE_W-1:0]   slot_be   [DEPTH],
   output logic [CNT_W-1:0]  occ
);
   // Slot 0 always holds the oldest entry; removal compacts younger ones down.
   logic              vld_q   [DEPTH];
   logic              fence_q [DEPTH];
   logic [ADDR_W-1:0] addr_q  [DEPTH];
   logic [DATA_W-1:0] data_q  [DEPTH];
   logic [BE_W-1:0]   be_q    [DEPTH];

   logic              sh_vld   [DEPTH];
   logic              sh_fence [DEPTH];
   logic [ADDR_W-1:0] sh_addr  [DEPTH];
   logic [DATA_W-1:0] sh_data  [DEPTH];
   logic [BE_W-1:0]   sh_be    [DEPTH];

   logic [CNT_W-1:0]  cnt_after;

   assign occ       = CNT_W'($countones(slot_vld));
   assign cnt_after = occ - CNT_W'(pop);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic take;
      logic wr_new;

      assign take   = pop && (IDX_W'(i) >= pop_idx);
      assign wr_new = push && (cnt_after == CNT_W'(i));

      if (i == DEPTH - 1) begin : g_top
         assign sh_vld[i]   = take ? 1'b0 : vld_q[i];
         assign sh_fence[i] = fence_q[i];
         assign sh_addr[i]  = addr_q[i];
         assign sh_data[i]  = data_q[i];
         assign sh_be[i]    = be_q[i];
      end else begin : g_mid
         assign sh_vld[i]   = take ? vld_q[i+1]   : vld_q[i];
         assign sh_fence[i] = take ? fence_q[i+1] : fence_q[i];
         assign sh_addr[i]  = take ? addr_q[i+1]  : addr_q[i];
         assign sh_data[i]  = take ? data_q[i+1]  : data_q[i];
         assign sh_be[i]    = take ? be_q[i+1]    : be_q[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) vld_q[i] <= 1'b0;
         else        vld_q[i] <= wr_new | sh_vld[i];
      end

      always_ff @(posedge clk) begin
         if (wr_new) begin
            fence_q[i] <= (push_kind == SB_FENCE);
            addr_q[i]  <= push_addr;
            data_q[i]  <= push_data;
            be_q[i]    <= push_be;
         end else begin
            fence_q[i] <= sh_fence[i];
            addr_q[i]  <= sh_addr[i];
            data_q[i]  <= sh_data[i];
            be_q[i]    <= sh_be[i];
         end
      end

      assign slot_vld[i]   = vld_q[i];
      assign slot_fence[i] = fence_q[i];
      assign slot_addr[i]  = addr_q[i];
      assign slot_data[i]  = data_q[i];
      assign slot_be[i]    = be_q[i];
   end
endmodule

// File: rtl/sb_picker.sv
module sb_picker #(
   parameter int DEPTH    = 8,
   parameter int ADDR_W   = 16,
   parameter int NBANK    = 4,
   parameter bit RELAX_EN = 1'b1,
   localparam int IDX_W     = $clog2(DEPTH),
   localparam int BANK_BITS = $clog2(NBANK)
) (
   input  logic              relax,
   input  logic [DEPTH-1:0]  slot_vld,
   input  logic [DEPTH-1:0]  slot_fence,
   input  logic [ADDR_W-1:0] slot_addr [DEPTH],
   input  logic [NBANK-1:0]  bank_busy,
   output logic              st_hit,
   output logic [IDX_W-1:0]  st_idx,
   output logic              fence_ret
);
   logic [DEPTH-1:0] rdy;

   for (genvar i = 0; i < DEPTH; i++) begin : g_rdy
      assign rdy[i] = slot_vld[i] && !slot_fence[i]
                      && !bank_busy[slot_addr[i][BANK_BITS-1:0]];
   end

   // A fence leaves by itself once nothing older remains.
   assign fence_ret = slot_vld[0] && slot_fence[0];

   if (RELAX_EN) begin : g_relax
      logic [DEPTH-1:0] elig;
      logic             r_hit;
      logic [IDX_W-1:0] r_idx;

      always_comb begin
         for (int i = 0; i < DEPTH; i++) begin
            logic blk;
            blk = 1'b0;
            for (int j = 0; j < i; j++) begin
               if (slot_vld[j] && (slot_fence[j] || slot_addr[j] == slot_addr[i]))
                  blk = 1'b1;
            end
            elig[i] = rdy[i] && !blk;
         end
      end

      always_comb begin
         r_hit = 1'b0;
         r_idx = '0;
         for (int i = DEPTH - 1; i >= 0; i--) begin
            if (elig[i]) begin
               r_hit = 1'b1;
               r_idx = IDX_W'(i);
            end
         end
      end

      assign st_hit = relax ? r_hit : rdy[0];
      assign st_idx = relax ? r_idx : '0;
   end else begin : g_strict
      logic unused_relax;
      assign unused_relax = relax;
      assign st_hit = rdy[0];
      assign st_idx = '0;
   end
endmodule

// File: rtl/sb_flush_ctl.sv
module sb_flush_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic flush_req,
   input  logic empty,
   output logic busy,
   output logic done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
      end else if (busy && empty) begin
         busy <= 1'b0;
         done <= 1'b1;
      end else begin
         done <= 1'b0;
         if (flush_req) busy <= 1'b1;
      end
   end
endmodule

// File: rtl/store_drain_buf.sv
module store_drain_buf
   import sb_pkg::*;
#(
   parameter int DEPTH    = 8,
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 32,
   parameter int NBANK    = 4,
   parameter bit RELAX_EN = 1'b1,
   localparam int BE_W      = DATA_W / 8,
   localparam int IDX_W     = $clog2(DEPTH),
   localparam int CNT_W     = $clog2(DEPTH + 1),
   localparam int BANK_BITS = $clog2(NBANK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              relax_mode,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic              s_fence,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic [DATA_W-1:0] s_data,
   input  logic [BE_W-1:0]   s_be,
   output logic              m_valid,
   input  logic              m_ready,
   output logic [ADDR_W-1:0] m_addr,
   output logic [DATA_W-1:0] m_data,
   output logic [BE_W-1:0]   m_be,
   input  logic [NBANK-1:0]  m_bank_busy,
   input  logic              flush_req,
   output logic              flush_done
);
   if (DEPTH < 2 || DEPTH > 32) begin : g_bad_depth
      $error("store_drain_buf: DEPTH must lie in 2..32");
   end
   if (NBANK < 2 || (NBANK & (NBANK - 1)) != 0) begin : g_bad_bank
      $error("store_drain_buf: NBANK must be a power of two, at least 2");
   end
   if (DATA_W % 8 != 0) begin : g_bad_data
      $error("store_drain_buf: DATA_W must be a whole number of bytes");
   end
   if (ADDR_W <= BANK_BITS) begin : g_bad_addr
      $error("store_drain_buf: ADDR_W too narrow for bank select");
   end

   logic [DEPTH-1:0]  slot_vld;
   logic [DEPTH-1:0]  slot_fence;
   logic [ADDR_W-1:0] slot_addr [DEPTH];
   logic [DATA_W-1:0] slot_data [DEPTH];
   logic [BE_W-1:0]   slot_be   [DEPTH];
   logic [CNT_W-1:0]  occ;

   logic              st_hit;
   logic [IDX_W-1:0]  st_idx;
   logic              fence_ret;
   logic              flush_busy;
   logic              push;
   logic              pop;
   logic              m_fire;
   sb_kind_e          push_kind;

   assign s_ready   = !slot_vld[DEPTH-1] && !flush_busy;
   assign push      = s_valid && s_ready;
   assign push_kind = s_fence ? SB_FENCE : SB_STORE;
   assign m_valid   = st_hit;
   assign m_fire    = m_valid && m_ready;
   assign pop       = fence_ret || m_fire;
   assign m_addr    = slot_addr[st_idx];
   assign m_data    = slot_data[st_idx];
   assign m_be      = slot_be[st_idx];

   sb_slots #(
      .DEPTH (DEPTH),
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .BE_W  (BE_W)
   ) u_slots (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_kind (push_kind),
      .push_addr (s_addr),
      .push_data (s_data),
      .push_be   (s_be),
      .pop       (pop),
      .pop_idx   (fence_ret ? '0 : st_idx),
      .slot_vld  (slot_vld),
      .slot_fence(slot_fence),
      .slot_addr (slot_addr),
      .slot_data (slot_data),
      .slot_be   (slot_be),
      .occ       (occ)
   );

   sb_picker #(
      .DEPTH   (DEPTH),
      .ADDR_W  (ADDR_W),
      .NBANK   (NBANK),
      .RELAX_EN(RELAX_EN)
   ) u_pick (
      .relax     (relax_mode),
      .slot_vld  (slot_vld),
      .slot_fence(slot_fence),
      .slot_addr (slot_addr),
      .bank_busy (m_bank_busy),
      .st_hit    (st_hit),
      .st_idx    (st_idx),
      .fence_ret (fence_ret)
   );

   sb_flush_ctl u_flush (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush_req(flush_req),
      .empty    (occ == '0),
      .busy     (flush_busy),
      .done     (flush_done)
   );
endmodule

// File: rtl/sb_check.sv
module sb_check #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int NBANK  = 4,
   localparam int CNT_W     = $clog2(DEPTH + 1),
   localparam int BANK_BITS = $clog2(NBANK)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              relax_mode,
   input logic              s_valid,
   input logic              s_ready,
   input logic              m_valid,
   input logic              m_ready,
   input logic [ADDR_W-1:0] m_addr,
   input logic [DATA_W-1:0] m_data,
   input logic [NBANK-1:0]  m_bank_busy,
   input logic              flush_req,
   input logic              flush_done,
   input logic              fence_ret
);
   logic [CNT_W-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held <= '0;
      else held <= held + CNT_W'(s_valid && s_ready)
                        - CNT_W'((m_valid && m_ready) || fence_ret);
   end

   always_comb begin
      if (rst_n) p_held_range_r2: assert (held <= CNT_W'(DEPTH));
   end

   p_full_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (held == CNT_W'(DEPTH)) |-> !s_ready);

   p_bank_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> !m_bank_busy[m_addr[BANK_BITS-1:0]]);

   p_strict_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!relax_mode && !$past(relax_mode) && $past(m_valid && !m_ready)
       && $stable(m_bank_busy))
      |-> (m_valid && $stable(m_addr) && $stable(m_data)));

   p_fence_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fence_ret |-> !m_valid);

   p_flush_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |=> !s_ready);

   p_done_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_done |-> (held == '0));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_done |=> !flush_done);
endmodule

bind store_drain_buf sb_check #(
   .DEPTH (DEPTH),
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W),
   .NBANK (NBANK)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .relax_mode (relax_mode),
   .s_valid    (s_valid),
   .s_ready    (s_ready),
   .m_valid    (m_valid),
   .m_ready    (m_ready),
   .m_addr     (m_addr),
   .m_data     (m_data),
   .m_bank_busy(m_bank_busy),
   .flush_req  (flush_req),
   .flush_done (flush_done),
   .fence_ret  (fence_ret)
);

// File: tb/store_drain_buf_tb_top.sv
module store_drain_buf_tb_top;
   localparam int DEPTH  = 8;
   localparam int ADDR_W = 16;
   localparam int DATA_W = 32;
   localparam int NBANK  = 4;
   localparam int BE_W   = DATA_W / 8;
   localparam int NV     = 6;

   // Stimulus table: address, data, and the expected relaxed drain order
   // when bank 0 is busy at first and released later.
   localparam logic [ADDR_W-1:0] V_ADDR [NV] = '{16'h0010, 16'h0021, 16'h0010,
                                                 16'h0032, 16'h0021, 16'h0043};
   localparam logic [DATA_W-1:0] V_DATA [NV] = '{32'hA000_0000, 32'hA000_0001,
                                                 32'hA000_0002, 32'hA000_0003,
                                                 32'hA000_0004, 32'hA000_0005};
   localparam int EXP_RELAX [NV] = '{1, 3, 4, 5, 0, 2};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              relax_mode = 1'b0;
   logic              s_valid = 1'b0;
   logic              s_ready;
   logic              s_fence = 1'b0;
   logic [ADDR_W-1:0] s_addr = '0;
   logic [DATA_W-1:0] s_data = '0;
   logic [BE_W-1:0]   s_be = '0;
   logic              m_valid;
   logic              m_ready = 1'b0;
   logic [ADDR_W-1:0] m_addr;
   logic [DATA_W-1:0] m_data;
   logic [BE_W-1:0]   m_be;
   logic [NBANK-1:0]  m_bank_busy = '0;
   logic              flush_req = 1'b0;
   logic              flush_done;

   int n_cmp = 0;
   int n_bad = 0;
   bit reported = 1'b0;

   logic [DATA_W-1:0] log_data [64];
   int nlog = 0;
   int ndone = 0;
   int done_nlog = -1;

   always #10 clk = ~clk;

   store_drain_buf #(
      .DEPTH (DEPTH),
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .NBANK (NBANK)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .relax_mode (relax_mode),
      .s_valid    (s_valid),
      .s_ready    (s_ready),
      .s_fence    (s_fence),
      .s_addr     (s_addr),
      .s_data     (s_data),
      .s_be       (s_be),
      .m_valid    (m_valid),
      .m_ready    (m_ready),
      .m_addr     (m_addr),
      .m_data     (m_data),
      .m_be       (m_be),
      .m_bank_busy(m_bank_busy),
      .flush_req  (flush_req),
      .flush_done (flush_done)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (m_valid && m_ready && nlog < 64) begin
            log_data[nlog] = m_data;
            nlog = nlog + 1;
         end
         if (flush_done) begin
            ndone = ndone + 1;
            done_nlog = nlog;
         end
      end
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic push(input logic f, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      bit ok;
      s_valid = 1'b1;
      s_fence = f;
      s_addr  = a;
      s_data  = d;
      s_be    = '1;
      do begin
         @(negedge clk);
         ok = s_ready;
         @(posedge clk);
         #1;
      end while (!ok);
      s_valid = 1'b0;
      s_fence = 1'b0;
   endtask

   initial begin
      #(20 * 100000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      bit seen;
      // R1: reset state
      idle(3);
      check("R1 s_ready in reset", s_ready, 1);
      check("R1 m_valid in reset", m_valid, 0);
      check("R1 flush_done in reset", flush_done, 0);
      rst_n = 1'b1;
      idle(2);
      check("R1 s_ready after reset", s_ready, 1);

      // R3: strict order, head blocked by busy bank 0
      relax_mode  = 1'b0;
      m_bank_busy = 4'b0001;
      for (int i = 0; i < NV; i++) push(1'b0, V_ADDR[i], V_DATA[i]);
      check("R3 no offer while head bank busy", m_valid, 0);
      m_ready = 1'b1;
      idle(8);
      check("R3 nothing passed blocked head", nlog, 0);
      m_bank_busy = '0;
      idle(10);
      check("R3 strict drain count", nlog, NV);
      for (int i = 0; i < NV; i++)
         check($sformatf("R3 R5 strict slot %0d", i), log_data[i], V_DATA[i]);

      // R8: stalled offer holds steady, nothing retires
      nlog = 0;
      m_ready = 1'b0;
      push(1'b0, 16'h0055, 32'h5555_0001);
      idle(3);
      check("R8 offer while stalled", m_valid, 1);
      check("R8 offered data steady", m_data, 32'h5555_0001);
      check("R8 no retire without ready", nlog, 0);
      m_ready = 1'b1;
      idle(3);
      check("R8 retire on handshake", nlog, 1);

      // R4: relaxed, bank 0 busy first
      nlog = 0;
      relax_mode  = 1'b1;
      m_ready     = 1'b0;
      m_bank_busy = 4'b0001;
      for (int i = 0; i < NV; i++) push(1'b0, V_ADDR[i], V_DATA[i]);
      m_ready = 1'b1;
      idle(10);
      check("R4 idle-bank stores drained", nlog, 4);
      check("R7 bank0 store not offered", (m_valid && m_addr[1:0] == 2'b00), 0);
      m_bank_busy = '0;
      idle(6);
      check("R4 relaxed drain count", nlog, NV);
      for (int i = 0; i < NV; i++)
         check($sformatf("R4 R5 relaxed slot %0d", i), log_data[i], V_DATA[EXP_RELAX[i]]);

      // R6: fence blocks a younger store to an idle bank
      nlog = 0;
      m_ready     = 1'b0;
      m_bank_busy = 4'b0001;
      push(1'b0, 16'h0100, 32'hB000_0000);
      push(1'b1, 16'h0000, 32'h0);
      push(1'b0, 16'h0101, 32'hB000_0001);
      m_ready = 1'b1;
      idle(6);
      check("R6 younger store held behind fence", nlog, 0);
      m_bank_busy = '0;
      idle(6);
      check("R6 fence makes no write", nlog, 2);
      check("R6 first write", log_data[0], 32'hB000_0000);
      check("R6 second write", log_data[1], 32'hB000_0001);

      // R2: capacity and refused ninth store
      nlog = 0;
      relax_mode = 1'b0;
      m_ready = 1'b0;
      for (int i = 0; i < DEPTH; i++) push(1'b0, 16'h0200 + 16'(i), 32'hC000_0000 + i);
      check("R2 s_ready low when full", s_ready, 0);
      s_valid = 1'b1;
      s_addr  = 16'h0300;
      s_data  = 32'hDEAD_BEEF;
      idle(3);
      s_valid = 1'b0;
      m_ready = 1'b1;
      idle(14);
      check("R2 only held entries drained", nlog, DEPTH);
      seen = 1'b0;
      for (int i = 0; i < nlog; i++) if (log_data[i] == 32'hDEAD_BEEF) seen = 1'b1;
      check("R2 refused store absent", seen, 0);
      check("R2 s_ready back after drain", s_ready, 1);

      // R9 / R10: flush with held entries
      nlog = 0;
      ndone = 0;
      m_ready = 1'b0;
      for (int i = 0; i < 3; i++) push(1'b0, 16'h0400 + 16'(i), 32'hD000_0000 + i);
      flush_req = 1'b1;
      idle(1);
      flush_req = 1'b0;
      check("R9 s_ready low during flush", s_ready, 0);
      idle(3);
      check("R10 no early done", ndone, 0);
      check("R9 still stalled", s_ready, 0);
      m_ready = 1'b1;
      idle(8);
      check("R9 flushed entries drained", nlog, 3);
      check("R10 single done pulse", ndone, 1);
      check("R10 done after last write", done_nlog, 3);
      check("R9 s_ready after done", s_ready, 1);

      // R10: flush of an empty buffer
      flush_req = 1'b1;
      idle(1);
      flush_req = 1'b0;
      check("R10 empty flush edge 1", flush_done, 0);
      idle(1);
      check("R10 empty flush edge 2", flush_done, 1);
      idle(1);
      check("R10 empty flush pulse ends", flush_done, 0);

      report();
      $finish;
   end
endmodule